// File: doc/BRIEF.md
# Current-Detect Interrupt Flag Controller

This peripheral slice turns the digital output of an external current-sense comparator into a sticky interrupt flag. The comparator line is asynchronous to the core clock. It passes through a synchronizer, and any sampled high level sets the flag. Software can read the flag but cannot write it. It is cleared only by writing 1 to a separate acknowledge bit. An interrupt request and a wake-up request are derived from the flag and an enable bit.

The flag level can also be routed onto one of two port pins, in place of the ordinary port data. An enable bit and a select bit choose the pin. When a mask option assigns those pins to an external oscillator, the routing is suppressed. In the low-power stop mode the detector is disabled. A flag that is already set still requests a wake-up. In wait mode the detector keeps running.

Register map (byte bus, address width 2):
- Address 0, status: bit 7 is the flag (read-only), bit 6 is the acknowledge bit (write 1 to clear, reads 0), bit 0 is the interrupt enable.
- Address 1, control: bit 0 is the pin-route enable, bit 1 is the pin select.
- All other bits and addresses read as 0.

Top module: `cdet_flag_ctrl`

## Requirements
- R1: A high level on `cmp_trip_i` present at a rising edge shows as status bit 7 = 1 after the third rising edge counted from that one (two synchronizer stages, then the flag register), provided stop mode is not active.
- R2: `irq_o` is 1 exactly when the flag (status bit 7) and the interrupt enable (status bit 0) are both 1.
- R3: Writing status with bit 6 = 1 clears the flag at that edge. Writing to bit 7 never changes the flag. Bit 6 always reads 0.
- R4: When a synchronized trip sample and a clear write fall on the same edge, the flag ends up set.
- R5: After reset, the flag, interrupt enable, route enable and select all read 0, and `irq_o` and `wake_o` are 0.
- R6: With the route enable at 0, `pin_o[0]` = `port_dout_i[0]` and `pin_o[1]` = `port_dout_i[1]`. With the route enable at 1, the pin whose index equals the select bit carries the flag, and the other pin carries its port data.
- R7: While `osc_pins_i` = 1, both pins carry their port data whatever the enable, select and flag.
- R8: While `stop_i` = 1, a synchronized trip sample does not set the flag, and a set flag stays set unless cleared.
- R9: `wake_o` = flag AND interrupt enable AND (`stop_i` OR `wait_i`), with no register delay.
- R10: The interrupt enable, route enable and select bits read back what was last written to them. The control register's other bits, and addresses 2 and 3, read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_trip_i | input | 1 | Comparator output, asynchronous, high at or past trip threshold |
| osc_pins_i | input | 1 | Mask option: pins used by external oscillator |
| wait_i | input | 1 | Wait mode active |
| stop_i | input | 1 | Stop mode active |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i`, combinational |
| port_dout_i | input | 2 | Ordinary port data for the two pins |
| pin_o | output | 2 | Pin output after routing |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake-up request for wait/stop |

## Verification
A synchronized trip sample and a clear write can land on the same clock edge. Stop mode can also mask that same sample. The bench provokes the collision directly: it holds the comparator high while writing the acknowledge bit, both with stop low and with stop high. It also lets constrained-random traffic produce collisions at random. A cycle-level reference model in the bench predicts the flag after every edge, from set-over-clear priority and stop gating. The bench compares that prediction with the status read-back, the pins, `irq_o` and `wake_o` in every cycle.

// File: rtl/cdet_pkg.sv
package cdet_pkg;
  localparam int DW    = 8;
  localparam int AW    = 2;
  localparam int NPINS = 2;

  localparam logic [AW-1:0] ADDR_STAT = 2'd0;
  localparam logic [AW-1:0] ADDR_CTRL = 2'd1;

  localparam int STAT_FLAG_BIT = 7;
  localparam int STAT_ACK_BIT  = 6;
  localparam int STAT_IE_BIT   = 0;
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_SEL_BIT  = 1;

  // True when pin 'idx' must show the flag instead of port data.
  function automatic logic pin_takes_flag(logic en, logic sel, logic osc, int idx);
    return en && !osc && (int'(sel) == idx);
  endfunction

  // Next flag value: a set sample dominates a clear write.
  function automatic logic flag_next(logic cur, logic set_ev, logic clr_ev);
    if (set_ev) return 1'b1;
    if (clr_ev) return 1'b0;
    return cur;
  endfunction
endpackage

// File: rtl/cdet_sync.sv
module cdet_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/cdet_regs.sv
module cdet_regs
  import cdet_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_i,
  input  logic          stop_i,
  input  logic          bus_wr_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          flag_o,
  output logic          ie_o,
  output logic          en_o,
  output logic          sel_o,
  output logic          set_evt_o,
  output logic          clr_evt_o
);
  logic flag_q, ie_q, en_q, sel_q;
  logic wr_stat, wr_ctrl;
  logic unused_wbits;

  assign wr_stat   = bus_wr_i && (bus_addr_i == ADDR_STAT);
  assign wr_ctrl   = bus_wr_i && (bus_addr_i == ADDR_CTRL);
  assign set_evt_o = sample_i && !stop_i;
  assign clr_evt_o = wr_stat && bus_wdata_i[STAT_ACK_BIT];
  assign unused_wbits = ^bus_wdata_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      ie_q   <= 1'b0;
      en_q   <= 1'b0;
      sel_q  <= 1'b0;
    end else begin
      flag_q <= flag_next(flag_q, set_evt_o, clr_evt_o);
      if (wr_stat) ie_q <= bus_wdata_i[STAT_IE_BIT];
      if (wr_ctrl) begin
        en_q  <= bus_wdata_i[CTRL_EN_BIT];
        sel_q <= bus_wdata_i[CTRL_SEL_BIT];
      end
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      ADDR_STAT: begin
        bus_rdata_o[STAT_FLAG_BIT] = flag_q;
        bus_rdata_o[STAT_IE_BIT]   = ie_q;
      end
      ADDR_CTRL: begin
        bus_rdata_o[CTRL_EN_BIT]  = en_q;
        bus_rdata_o[CTRL_SEL_BIT] = sel_q;
      end
      default: bus_rdata_o = '0;
    endcase
  end

  assign flag_o = flag_q;
  assign ie_o   = ie_q;
  assign en_o   = en_q;
  assign sel_o  = sel_q;

  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt_o && clr_evt_o) |=> flag_q);
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt_o && !set_evt_o) |=> !flag_q);
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_evt_o) |=> flag_q);
  p_stop_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !flag_q) |=> !flag_q);
endmodule

// File: rtl/cdet_pinmux.sv
module cdet_pinmux
  import cdet_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flag_i,
  input  logic             en_i,
  input  logic             sel_i,
  input  logic             osc_i,
  input  logic [NPINS-1:0] port_dout_i,
  output logic [NPINS-1:0] pin_o
);
  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    assign pin_o[g] = pin_takes_flag(en_i, sel_i, osc_i, g) ? flag_i : port_dout_i[g];
  end

  p_osc_keeps_port_r7: assert property (@(posedge clk) disable iff (!rst_n)
    osc_i |-> (pin_o == port_dout_i));
  p_disabled_port_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> (pin_o == port_dout_i));
endmodule

// File: rtl/cdet_flag_ctrl.sv
module cdet_flag_ctrl
  import cdet_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_trip_i,
  input  logic             osc_pins_i,
  input  logic             wait_i,
  input  logic             stop_i,
  input  logic             bus_wr_i,
  input  logic [AW-1:0]    bus_addr_i,
  input  logic [DW-1:0]    bus_wdata_i,
  output logic [DW-1:0]    bus_rdata_o,
  input  logic [NPINS-1:0] port_dout_i,
  output logic [NPINS-1:0] pin_o,
  output logic             irq_o,
  output logic             wake_o
);
  logic trip_sync;
  logic flag, ie, en, sel;
  logic set_evt, clr_evt;

  cdet_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (cmp_trip_i),
    .sync_o  (trip_sync)
  );

  cdet_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_i    (trip_sync),
    .stop_i      (stop_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .flag_o      (flag),
    .ie_o        (ie),
    .en_o        (en),
    .sel_o       (sel),
    .set_evt_o   (set_evt),
    .clr_evt_o   (clr_evt)
  );

  cdet_pinmux u_pinmux (
    .clk         (clk),
    .rst_n       (rst_n),
    .flag_i      (flag),
    .en_i        (en),
    .sel_i       (sel),
    .osc_i       (osc_pins_i),
    .port_dout_i (port_dout_i),
    .pin_o       (pin_o)
  );

  assign irq_o  = flag && ie;
  assign wake_o = irq_o && (stop_i || wait_i);

  p_irq_needs_both_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (bus_addr_i != ADDR_STAT || (bus_rdata_o[STAT_FLAG_BIT] && bus_rdata_o[STAT_IE_BIT])));
  p_wake_needs_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> (irq_o && (stop_i || wait_i)));
  p_sync_to_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_sync && !stop_i) |=> flag);
  p_ack_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rdata_o[STAT_ACK_BIT]);
endmodule

// File: tb/tb_cdet_flag_ctrl.sv
module tb_cdet_flag_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmp_trip_i = 1'b0, osc_pins_i = 1'b0, wait_i = 1'b0, stop_i = 1'b0;
  logic       bus_wr_i = 1'b0;
  logic [1:0] bus_addr_i = 2'd0;
  logic [7:0] bus_wdata_i = 8'd0;
  logic [7:0] bus_rdata_o;
  logic [1:0] port_dout_i = 2'd0;
  logic [1:0] pin_o;
  logic       irq_o, wake_o;

  int vectors = 0;
  int miscompares = 0;
  int collisions = 0;
  bit done = 1'b0;

  // reference state
  logic m_s1 = 0, m_s2 = 0, m_flag = 0, m_ie = 0, m_en = 0, m_sel = 0;

  always #2.5 clk = ~clk;

  cdet_flag_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cmp_trip_i(cmp_trip_i), .osc_pins_i(osc_pins_i),
    .wait_i(wait_i), .stop_i(stop_i), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .port_dout_i(port_dout_i),
    .pin_o(pin_o), .irq_o(irq_o), .wake_o(wake_o)
  );

  function automatic logic [7:0] exp_rdata(logic [1:0] a);
    if (a == 2'd0) return {m_flag, 7'b0} | {7'b0, m_ie};
    if (a == 2'd1) return {6'b0, m_sel, m_en};
    return 8'h00;
  endfunction

  function automatic logic exp_pin(int idx);
    if (m_en && !osc_pins_i && (m_sel ? 1 : 0) == idx) return m_flag;
    return port_dout_i[idx];
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Apply one vector at the falling edge, compare, then advance the model.
  task automatic step(logic trip, logic osc, logic wt, logic st, logic [1:0] pd,
                      logic wr, logic [1:0] addr, logic [7:0] wd);
    logic set_e, clr_e;
    @(negedge clk);
    cmp_trip_i = trip; osc_pins_i = osc; wait_i = wt; stop_i = st;
    port_dout_i = pd; bus_wr_i = wr; bus_addr_i = addr; bus_wdata_i = wd;
    #1;
    vectors++;
    check("R10/R1 rdata", bus_rdata_o, exp_rdata(addr));
    check(osc ? "R7 pin0" : "R6 pin0", {7'b0, pin_o[0]}, {7'b0, exp_pin(0)});
    check(osc ? "R7 pin1" : "R6 pin1", {7'b0, pin_o[1]}, {7'b0, exp_pin(1)});
    check("R2 irq", {7'b0, irq_o}, {7'b0, m_flag & m_ie});
    check("R9 wake", {7'b0, wake_o}, {7'b0, m_flag & m_ie & (st | wt)});
    set_e = m_s2 && !st;
    clr_e = wr && addr == 2'd0 && wd[6];
    if (set_e && clr_e) collisions++;
    @(posedge clk);
    m_flag = set_e ? 1'b1 : (clr_e ? 1'b0 : m_flag);
    m_s2 = m_s1; m_s1 = trip;
    if (wr && addr == 2'd0) m_ie = wd[0];
    if (wr && addr == 2'd1) begin m_en = wd[0]; m_sel = wd[1]; end
  endtask

  initial begin
    #200000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int seed;
    int r;
    seed = 20240517;
    r = $urandom(seed);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R5 reset state
    step(0, 0, 0, 0, 2'b00, 0, 2'd0, 8'h00);
    check("R5 stat", bus_rdata_o, 8'h00);
    step(0, 0, 0, 0, 2'b11, 0, 2'd1, 8'h00);
    check("R5 ctrl", bus_rdata_o, 8'h00);
    // R1 latency: one-cycle pulse, flag after third edge
    step(1, 0, 0, 0, 2'b00, 0, 2'd0, 8'h00);
    step(0, 0, 0, 0, 2'b00, 0, 2'd0, 8'h00);
    step(0, 0, 0, 0, 2'b00, 0, 2'd0, 8'h00);
    check("R1 not yet", bus_rdata_o, 8'h00);
    step(0, 0, 0, 0, 2'b00, 0, 2'd0, 8'h00);
    check("R1 set", bus_rdata_o, 8'h80);
    // R3 write to flag bit only: no effect; enable irq
    step(0, 0, 0, 0, 2'b00, 1, 2'd0, 8'h81);
    step(0, 0, 0, 0, 2'b00, 0, 2'd0, 8'h00);
    check("R3 flag write ignored", bus_rdata_o, 8'h81);
    check("R2 irq on", {7'b0, irq_o}, 8'h01);
    // R6 route to pin 1, port data 0
    step(0, 0, 0, 0, 2'b00, 1, 2'd1, 8'h03);
    step(0, 0, 0, 0, 2'b00, 0, 2'd1, 8'h00);
    check("R6 pin1 flag", {6'b0, pin_o}, 8'h02);
    // R7 oscillator option
    step(0, 1, 0, 0, 2'b01, 0, 2'd1, 8'h00);
    check("R7 osc", {6'b0, pin_o}, 8'h01);
    // R9 wake in stop
    step(0, 0, 0, 1, 2'b00, 0, 2'd0, 8'h00);
    check("R9 wake stop", {7'b0, wake_o}, 8'h01);
    // R3 clear, ack reads 0
    step(0, 0, 0, 0, 2'b00, 1, 2'd0, 8'h41);
    step(0, 0, 0, 0, 2'b00, 0, 2'd0, 8'h00);
    check("R3 cleared", bus_rdata_o, 8'h01);
    // R4 collision: hold trip, clear while sample high
    step(1, 0, 0, 0, 2'b00, 0, 2'd0, 8'h00);
    step(1, 0, 0, 0, 2'b00, 0, 2'd0, 8'h00);
    step(1, 0, 0, 0, 2'b00, 1, 2'd0, 8'h41);
    step(0, 0, 0, 0, 2'b00, 0, 2'd0, 8'h00);
    check("R4 set wins", bus_rdata_o, 8'h81);
    // R8 stop blocks set: clear, then trip in stop
    step(0, 0, 0, 1, 2'b00, 1, 2'd0, 8'h41);
    step(1, 0, 0, 1, 2'b00, 0, 2'd0, 8'h00);
    step(1, 0, 0, 1, 2'b00, 0, 2'd0, 8'h00);
    step(1, 0, 0, 1, 2'b00, 1, 2'd0, 8'h41);
    step(0, 0, 0, 1, 2'b00, 0, 2'd0, 8'h00);
    check("R8 stop no set", bus_rdata_o, 8'h01);
    // R10 unused address ignores writes
    step(0, 0, 0, 0, 2'b00, 1, 2'd3, 8'hFF);
    step(0, 0, 0, 0, 2'b00, 0, 2'd3, 8'h00);
    check("R10 addr3", bus_rdata_o, 8'h00);
    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic wr;
      logic [7:0] wd;
      wr = ($urandom % 100) < 30;
      wd = $urandom;
      if (($urandom % 4) == 0) wd[6] = 1'b1;
      step(($urandom % 3) != 0, ($urandom % 8) == 0, ($urandom % 6) == 0,
           ($urandom % 10) == 0, 2'($urandom), wr, 2'($urandom), wd);
    end
    if (collisions == 0) begin
      miscompares++;
      $display("FAIL R4: actual 0 collisions expected >0");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule